// File: doc/BRIEF.md
# High-Speed Lane Settle Timer and Sync Aligner

This block serves one receive data lane of a source-synchronous serial camera link. It runs in the DDR bit-clock domain and receives one deserialized byte per cycle, together with a flag that is high while the line is in the low-power stop state. When the line leaves the stop state for a high-speed burst, a single cycle counter starts. The counter is compared against two programmable delays. The first delay turns on line termination. The second masks the settle period. After the settle period, the block opens a byte-alignment search.

The search looks at a 16-bit window made of the current byte and the previous byte. It compares all eight bit offsets against a programmable sync byte at once. On the first hit, the block locks the offset and raises `aligned`. From the next cycle on, it re-slices the stream at that offset and presents each payload byte with a valid flag. When the line returns to the stop state, the block clears its state and waits for the next burst.

The three configuration fields are held in local registers. A single write strobe loads all three. The settle field is raised to a floor of 3 when it is used, and the stored value is left as written. The floor of 3 applies to the effective settle value. The extra pipeline stage in the data path means the search opens one count earlier than the raw compare would suggest.

Top module: `hs_lane_sync_rx`

## Requirements
- R1: After reset, `term_en`, `search_en`, `aligned` and `byte_vld` are low. The configuration fields hold termination delay 4, settle delay 39 and sync byte 0xB8.
- R2: Edges are counted from 1 at the first rising edge that samples `lp_stop` low. `term_en` is high after edge `T+1` and later, and low before that, where `T` is the stored termination delay.
- R3: `search_en` is high after edge `max(S,3)` and later, and low before that, where `S` is the stored settle delay.
- R4: A settle value of 0, 1 or 2 behaves exactly like 3.
- R5: Bit 0 of `ser_byte` is the earliest-received bit. Bit 0 of the sync byte is compared with the earliest bit of a candidate. A stream that carries the sync byte in the opposite bit order does not align.
- R6: The window is `{ser_byte, previous byte}`. At a rising edge where `search_en` is high, the sync byte at any offset 0 to 7 of this window sets `aligned` after that edge. The lowest matching offset is locked.
- R7: A sync byte whose window is presented while `search_en` is still low is not detected.
- R8: After the (i+1)-th edge that follows the aligning edge, `byte_vld` is high. At that point `byte_out` equals the 8 stream bits that start 8·(i+1) bits after the first sync bit. `byte_vld` is low whenever `aligned` is low.
- R9: An edge that samples `lp_stop` high clears `term_en`, `search_en`, `aligned` and `byte_vld` after that edge.
- R10: An edge with `cfg_we` high loads `cfg_term`, `cfg_settle` and `cfg_sync`. The following bursts use these values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DDR bit-rate byte clock |
| rst_n | input | 1 | Active-low reset |
| lp_stop | input | 1 | High while the line is in the low-power stop state |
| ser_byte | input | 8 | Deserialized byte, bit 0 received first |
| cfg_we | input | 1 | Loads the three configuration fields |
| cfg_term | input | 8 | Termination delay in cycles |
| cfg_settle | input | 8 | Settle delay in cycles |
| cfg_sync | input | 8 | Sync byte, bit 0 = first-received bit |
| term_en | output | 1 | Line termination enable |
| search_en | output | 1 | Settle period over, alignment search open |
| aligned | output | 1 | Sync found, offset locked |
| byte_out | output | 8 | Aligned payload byte |
| byte_vld | output | 1 | `byte_out` holds a payload byte |

## Verification
The two timers are swept together over termination delays 0 to 5 and settle delays 0 to 6, with every edge of each burst compared. This separates an off-by-one in either compare from the floor of 3. The sync search is driven with two patterns at each of the eight bit offsets, and the payload bytes following each are checked. This shows whether the slicing, the offset priority and the bit order are right. Further bursts check three cases: a sync placed one byte before the search opens, the same sync placed just inside the open search, and a stream that carries the sync byte bit-reversed. The default configuration is used once straight out of reset.

// File: rtl/hs_lane_sync_rx.sv
module hs_lane_sync_rx #(
  parameter int          BW         = 8,
  parameter int          CW         = 8,
  parameter int          TERM_RST   = 4,
  parameter int          SETTLE_RST = 39,
  parameter int          SETTLE_MIN = 3,
  parameter logic [BW-1:0] SYNC_RST = 8'hB8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lp_stop,
  input  logic [BW-1:0] ser_byte,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_term,
  input  logic [CW-1:0] cfg_settle,
  input  logic [BW-1:0] cfg_sync,
  output logic          term_en,
  output logic          search_en,
  output logic          aligned,
  output logic [BW-1:0] byte_out,
  output logic          byte_vld
);
  localparam int OW = $clog2(BW);

  logic [CW-1:0]   term_q, settle_q, eff_settle, cnt;
  logic [BW-1:0]   sync_q, prev;
  logic [2*BW-1:0] win;
  logic [BW-1:0]   hit;
  logic [OW-1:0]   off, hit_off;
  logic            act, hit_any;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      term_q   <= CW'(TERM_RST);
      settle_q <= CW'(SETTLE_RST);
      sync_q   <= SYNC_RST;
    end else if (cfg_we) begin
      term_q   <= cfg_term;
      settle_q <= cfg_settle;
      sync_q   <= cfg_sync;
    end

  assign eff_settle = (settle_q < CW'(SETTLE_MIN)) ? CW'(SETTLE_MIN) : settle_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      act <= 1'b0;
      cnt <= '0;
    end else if (lp_stop) begin
      act <= 1'b0;
      cnt <= '0;
    end else begin
      act <= 1'b1;
      if (act && cnt != '1) cnt <= cnt + 1'b1;
    end

  assign term_en   = act && (cnt >= term_q);
  assign search_en = act && (({1'b0, cnt} + 1'b1) >= {1'b0, eff_settle});

  assign win = {ser_byte, prev};

  genvar g;
  generate
    for (g = 0; g < BW; g++) begin : g_cmp
      assign hit[g] = (win[g +: BW] == sync_q);
    end
  endgenerate

  always_comb begin
    hit_any = 1'b0;
    hit_off = '0;
    for (int k = BW - 1; k >= 0; k--)
      if (hit[k]) begin
        hit_any = 1'b1;
        hit_off = OW'(k);
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= '0;
    else        prev <= ser_byte;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      aligned  <= 1'b0;
      off      <= '0;
      byte_out <= '0;
      byte_vld <= 1'b0;
    end else if (lp_stop) begin
      aligned  <= 1'b0;
      byte_out <= '0;
      byte_vld <= 1'b0;
    end else begin
      if (search_en && !aligned && hit_any) begin
        aligned <= 1'b1;
        off     <= hit_off;
      end
      byte_vld <= aligned;
      if (aligned) byte_out <= win[off +: BW];
    end
endmodule

// File: rtl/hs_lane_sync_rx_chk.sv
module hs_lane_sync_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic lp_stop,
  input logic cfg_we,
  input logic term_en,
  input logic search_en,
  input logic aligned,
  input logic byte_vld
);
  // R9
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lp_stop |=> (!term_en && !search_en && !aligned && !byte_vld));

  // R8
  vld_needs_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> aligned);

  // R6
  align_after_search_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aligned) |-> $past(search_en));

  // R2
  term_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (term_en && !lp_stop && !cfg_we) |=> term_en);

  // R3
  search_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (search_en && !lp_stop && !cfg_we) |=> search_en);

  // R4
  settle_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(search_en) |-> ($past(!lp_stop) && $past(!lp_stop, 2)));
endmodule

bind hs_lane_sync_rx hs_lane_sync_rx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .lp_stop(lp_stop), .cfg_we(cfg_we),
  .term_en(term_en), .search_en(search_en), .aligned(aligned), .byte_vld(byte_vld)
);

// File: tb/hs_lane_sync_rx_tb_top.sv
module hs_lane_sync_rx_tb_top;
  logic       clk = 1'b0, rst_n = 1'b0, lp_stop = 1'b1, cfg_we = 1'b0;
  logic [7:0] ser_byte = '0, cfg_term = '0, cfg_settle = '0, cfg_sync = '0;
  logic       term_en, search_en, aligned, byte_vld;
  logic [7:0] byte_out;
  int         total = 0, bad = 0;

  always #2 clk = ~clk;

  hs_lane_sync_rx dut_i (
    .clk(clk), .rst_n(rst_n), .lp_stop(lp_stop), .ser_byte(ser_byte),
    .cfg_we(cfg_we), .cfg_term(cfg_term), .cfg_settle(cfg_settle), .cfg_sync(cfg_sync),
    .term_en(term_en), .search_en(search_en), .aligned(aligned),
    .byte_out(byte_out), .byte_vld(byte_vld)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr_cfg(input logic [7:0] t, input logic [7:0] s, input logic [7:0] p);
    @(negedge clk);
    cfg_we = 1'b1; cfg_term = t; cfg_settle = s; cfg_sync = p;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic stop_check();
    @(negedge clk); lp_stop = 1'b1; ser_byte = '0;
    @(negedge clk);
    chk({term_en, search_en, aligned, byte_vld} == 4'b0, "R9 stop clears",
        {term_en, search_en, aligned, byte_vld}, 0);
    @(negedge clk);
  endtask

  function automatic logic [7:0] pay(input int i, input int k);
    return 8'(8'h3C ^ (i * 37) ^ (k << 4) ^ k);
  endfunction

  task automatic timer_burst(input int t, input int s, input int edges, input string tag);
    int eff;
    eff = (s < 3) ? 3 : s;
    @(negedge clk); lp_stop = 1'b0; ser_byte = '0;
    for (int e = 1; e <= edges; e++) begin
      @(posedge clk); @(negedge clk);
      chk(term_en == (e >= t + 1), {tag, " R2 term_en"}, term_en, (e >= t + 1));
      chk(search_en == (e >= eff), (s < 3) ? {tag, " R4 settle floor"} : {tag, " R3 search_en"},
          search_en, (e >= eff));
    end
    @(negedge clk); lp_stop = 1'b1;
    @(negedge clk);
  endtask

  task automatic sync_burst(input int npre, input int k, input logic [7:0] sent,
                            input logic expect_hit, input string tag);
    logic [511:0] bits;
    int n;
    bits = '0;
    n = npre + 8;
    bits[8*npre + k +: 8] = sent;
    for (int i = 0; i < 6; i++) bits[8*npre + k + 8 + 8*i +: 8] = pay(i, k);
    @(negedge clk); lp_stop = 1'b0; ser_byte = bits[7:0];
    for (int e = 1; e <= n; e++) begin
      @(posedge clk); @(negedge clk);
      if (expect_hit) begin
        chk(aligned == (e >= npre + 2), {tag, " R6 aligned"}, aligned, (e >= npre + 2));
        chk(byte_vld == (e >= npre + 3), {tag, " R8 byte_vld"}, byte_vld, (e >= npre + 3));
        if (e >= npre + 3)
          chk(byte_out == pay(e - npre - 3, k), {tag, " R8 byte_out"}, byte_out,
              pay(e - npre - 3, k));
      end else begin
        chk(!aligned && !byte_vld, {tag, " no alignment"}, {aligned, byte_vld}, 0);
      end
      ser_byte = bits[8*e +: 8];
    end
    stop_check();
  endtask

  initial begin
    #800000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({term_en, search_en, aligned, byte_vld} == 4'b0, "R1 reset outputs",
        {term_en, search_en, aligned, byte_vld}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({term_en, search_en, aligned, byte_vld} == 4'b0, "R1 idle in stop",
        {term_en, search_en, aligned, byte_vld}, 0);

    // R1 defaults: termination 4, settle 39, sync 0xB8
    timer_burst(4, 39, 42, "R1 default timers");
    sync_burst(40, 3, 8'hB8, 1'b1, "R1 default sync");

    // R10 configuration sweep of both timers, settle below 3 included (R4)
    for (int t = 0; t <= 5; t++)
      for (int s = 0; s <= 6; s++) begin
        wr_cfg(8'(t), 8'(s), 8'hE5);
        timer_burst(t, s, 10, "R10 sweep");
      end

    // R5 R6 R8: every offset, two patterns
    wr_cfg(8'd0, 8'd3, 8'hE5);
    for (int k = 0; k < 8; k++) sync_burst(4, k, 8'hE5, 1'b1, "R5 offset E5");
    wr_cfg(8'd0, 8'd3, 8'h97);
    for (int k = 0; k < 8; k++) sync_burst(4, k, 8'h97, 1'b1, "R5 offset 97");

    // R5 bit-reversed sync must not align
    wr_cfg(8'd0, 8'd3, 8'hE5);
    sync_burst(4, 2, 8'hA7, 1'b0, "R5 reversed order");

    // R7 sync one byte before the search opens, then just inside it
    wr_cfg(8'd0, 8'd8, 8'hE5);
    sync_burst(6, 0, 8'hE5, 1'b0, "R7 early sync");
    sync_burst(7, 0, 8'hE5, 1'b1, "R7 sync at open");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule